// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block turns one register read or write request into the strobe-and-acknowledge sequence that a PHY control-register bus expects. The address space is 16 bits and the data is 16 bits. A request arrives on a valid/ready port with an address, write data and a direction flag. The master then drives a shared 16-bit bus toward the PHY and one of four one-bit strobes: address capture, data capture, read and write commit. It samples a 16-bit return bus and an acknowledge line.

Every access begins with an address phase. A read then follows with a read phase. A write follows with a data-capture phase and then a commit phase. Each strobe uses a full four-phase handshake: the strobe rises, ack rises, the strobe drops, and ack falls. Each wait for ack has a cycle bound set by a parameter. When the bound runs out, the access is abandoned, every strobe is released and the requester gets an error. The master never retries an access by itself.

Top module: `cr_bus_master`

## Requirements
- R1: Out of reset, req_ready is 1, all four strobes are 0, done is 0 and cr_data_in is 0.
- R2: After a request is accepted, the address sits on cr_data_in with no strobe for exactly SETUP_CYCLES cycles. Then cr_cap_addr is raised. The address stays on cr_data_in until ack has fallen after that strobe.
- R3: A read raises cr_rd with cr_data_in at 0. It latches cr_data_out in the cycle ack is seen high and returns that value on done_rdata with done_err 0. The write strobe never rises during a read.
- R4: A write drives the write data for SETUP_CYCLES cycles with no strobe. It then handshakes cr_cap_data, and then handshakes cr_wr, with the same data held on cr_data_in throughout. done_rdata is 0 when a write completes.
- R5: At most one of cr_cap_addr, cr_cap_data, cr_rd and cr_wr is 1 in any cycle.
- R6: req_ready is 0 from the cycle after acceptance until the cycle in which done is raised. req_ready is 1 in that cycle.
- R7: done is a single-cycle pulse. When every ack wait lasts W cycles, done rises SETUP_CYCLES + 4W clock edges after acceptance for a read, and 2*SETUP_CYCLES + 6W edges after acceptance for a write.
- R8: If ack has not risen within TMO_LIMIT cycles of a strobe's rise, the strobe is dropped and the access ends with done and done_err at 1. done_rdata is 0, and no later strobe of that access is issued.
- R9: If ack has not fallen within TMO_LIMIT cycles of a strobe's release, the access ends with done and done_err at 1 on the edge that closes the TMO_LIMIT-th cycle of that wait.
- R10: An ack that arrives in the TMO_LIMIT-th cycle of a wait is accepted. The wait bound restarts at every wait, so an access of six waits that each last TMO_LIMIT cycles completes without error.
- R11: After an aborted access the master stays idle: req_ready is 1, no strobe rises and no further done occurs until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Access aborted by an ack timeout (valid with done) |
| done_rdata | output | DW | Read result (valid with done) |
| cr_data_in | output | DW | Address or data driven toward the PHY |
| cr_cap_addr | output | 1 | Address capture strobe |
| cr_cap_data | output | 1 | Data capture strobe |
| cr_rd | output | 1 | Read strobe |
| cr_wr | output | 1 | Write commit strobe |
| cr_data_out | input | DW | Read data returned by the PHY |
| cr_ack | input | 1 | PHY acknowledge |

## Verification
The bench's PHY model changes ack on the falling edge after a delay of D cycles, so each ack wait lasts exactly D+1 cycles. A read's done therefore appears SETUP_CYCLES + 4(D+1) edges after acceptance, and a write's appears 2*SETUP_CYCLES + 6(D+1) edges after. The bench counts falling edges from the acceptance edge and expects done at the falling edge that follows the edge of that count. A timeout on a rising ack is due TMO_LIMIT edges after the strobe rises. A timeout on a falling ack is due TMO_LIMIT edges after the release. All outputs are sampled on falling edges, half a cycle after the register that drives them, and the cycle after done is checked to confirm the pulse has ended.

// File: rtl/cr_bus_master.sv
module cr_bus_master #(
  parameter int AW           = 16,
  parameter int DW           = 16,
  parameter int SETUP_CYCLES = 2,
  parameter int TMO_W        = 8,
  parameter int TMO_LIMIT    = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] done_rdata,
  output logic [DW-1:0] cr_data_in,
  output logic          cr_cap_addr,
  output logic          cr_cap_data,
  output logic          cr_rd,
  output logic          cr_wr,
  input  logic [DW-1:0] cr_data_out,
  input  logic          cr_ack
);

  localparam logic [TMO_W-1:0] SETUP_LAST = TMO_W'(SETUP_CYCLES - 1);
  localparam logic [TMO_W-1:0] TMO_LAST   = TMO_W'(TMO_LIMIT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ASET, S_ASTB, S_AREL, S_RSTB, S_RREL,
    S_WSET, S_DSTB, S_DREL, S_WSTB, S_WREL
  } st_t;

  st_t             st, nxt;
  logic [TMO_W-1:0] cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            wr_q, done_q, err_q;

  wire wait_hi = (st == S_ASTB) || (st == S_RSTB) || (st == S_DSTB) || (st == S_WSTB);
  wire wait_lo = (st == S_AREL) || (st == S_RREL) || (st == S_DREL) || (st == S_WREL);
  wire ack_ok  = wait_hi ? cr_ack : !cr_ack;
  wire in_addr = (st == S_ASET) || (st == S_ASTB) || (st == S_AREL);
  wire in_data = (st == S_WSET) || (st == S_DSTB) || (st == S_DREL) ||
                 (st == S_WSTB) || (st == S_WREL);

  always_comb begin
    case (st)
      S_ASTB:  nxt = S_AREL;
      S_AREL:  nxt = wr_q ? S_WSET : S_RSTB;
      S_RSTB:  nxt = S_RREL;
      S_DSTB:  nxt = S_DREL;
      S_DREL:  nxt = S_WSTB;
      S_WSTB:  nxt = S_WREL;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          rdata_q <= '0;
          cnt     <= '0;
          st      <= S_ASET;
        end
        S_ASET, S_WSET: begin
          if (cnt == SETUP_LAST) begin
            cnt <= '0;
            st  <= (st == S_ASET) ? S_ASTB : S_DSTB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (ack_ok) begin
            cnt <= '0;
            st  <= nxt;
            if (st == S_RSTB) rdata_q <= cr_data_out;
            if (st == S_RREL || st == S_WREL) done_q <= 1'b1;
          end else if (cnt == TMO_LAST) begin
            cnt     <= '0;
            st      <= S_IDLE;
            rdata_q <= '0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign done        = done_q;
  assign done_err    = err_q;
  assign done_rdata  = rdata_q;
  assign cr_cap_addr = (st == S_ASTB);
  assign cr_cap_data = (st == S_DSTB);
  assign cr_rd       = (st == S_RSTB);
  assign cr_wr       = (st == S_WSTB);
  assign cr_data_in  = in_addr ? DW'(addr_q) : (in_data ? wdata_q : '0);

  logic unused_ok;
  assign unused_ok = wait_lo;

endmodule

// File: rtl/cr_bus_master_chk.sv
module cr_bus_master_chk #(
  parameter int DW        = 16,
  parameter int TMO_W     = 8,
  parameter int TMO_LIMIT = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          done_err,
  input logic [DW-1:0] done_rdata,
  input logic [DW-1:0] cr_data_in,
  input logic          cr_cap_addr,
  input logic          cr_cap_data,
  input logic          cr_rd,
  input logic          cr_wr,
  input logic          cr_ack
);

  wire [3:0] stb = {cr_cap_addr, cr_cap_data, cr_rd, cr_wr};

  logic [TMO_W:0] hi_wait;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_wait <= '0;
    else if (stb != 4'b0 && !cr_ack) hi_wait <= hi_wait + 1'b1;
    else hi_wait <= '0;
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb) <= 1);

  // R3
  rd_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_rd |-> cr_data_in == '0);

  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_cap_addr) |-> $past(cr_data_in) == cr_data_in && $past(stb) == 4'b0);

  // R4
  wr_data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_wr) |-> $past(cr_data_in) == cr_data_in && $past(stb) == 4'b0);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R6
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ack_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wait <= (TMO_W+1)'(TMO_LIMIT));

  // R8
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> done_rdata == '0);

endmodule

bind cr_bus_master cr_bus_master_chk #(
  .DW(DW), .TMO_W(TMO_W), .TMO_LIMIT(TMO_LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_err(done_err), .done_rdata(done_rdata),
  .cr_data_in(cr_data_in), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
  .cr_rd(cr_rd), .cr_wr(cr_wr), .cr_ack(cr_ack)
);

// File: tb/cr_bus_master_tb_top.sv
`timescale 1ns/1ps
module cr_bus_master_tb_top;
  localparam int SETUP = 2;
  localparam int LIM   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, done_err;
  logic [15:0] done_rdata, cr_data_in;
  logic        cr_cap_addr, cr_cap_data, cr_rd, cr_wr;
  logic [15:0] cr_data_out = '0;
  logic        cr_ack = 1'b0;

  cr_bus_master #(.AW(16), .DW(16), .SETUP_CYCLES(SETUP), .TMO_W(6), .TMO_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .done_err(done_err), .done_rdata(done_rdata),
    .cr_data_in(cr_data_in), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
    .cr_rd(cr_rd), .cr_wr(cr_wr), .cr_data_out(cr_data_out), .cr_ack(cr_ack)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  int dly = 0, w = 0;
  bit stuck_lo = 0, stuck_hi = 0, arm = 0, seen_cap = 0;
  logic [15:0] mon_addr = '0, mon_wdata = '0, ph_addr = '0, ph_data = '0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  int wr_cnt = 0, pre_cnt = 0, addr_bad = 0, rd_bad = 0, wd_bad = 0, multi = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model and bus monitor
  initial begin
    forever begin
      @(negedge clk);
      if ($countones({cr_cap_addr, cr_cap_data, cr_rd, cr_wr}) > 1) multi++;
      if (arm && !req_ready && !seen_cap && !(cr_cap_addr | cr_cap_data | cr_rd | cr_wr)) begin
        pre_cnt++;
        if (cr_data_in != mon_addr) addr_bad++;
      end
      if (arm && cr_cap_addr) begin
        seen_cap = 1;
        if (cr_data_in != mon_addr) addr_bad++;
      end
      if (cr_rd && cr_data_in != 16'h0) rd_bad++;
      if ((cr_cap_data || cr_wr) && cr_data_in != mon_wdata) wd_bad++;
      if ((cr_cap_addr | cr_cap_data | cr_rd | cr_wr) && !cr_ack) begin
        if (!stuck_lo) begin
          if (w >= dly) begin
            cr_ack = 1'b1;
            w = 0;
            if (cr_cap_addr) ph_addr = cr_data_in;
            if (cr_cap_data) ph_data = cr_data_in;
            if (cr_wr) begin wr_cnt++; wr_addr = ph_addr; wr_data = ph_data; end
            if (cr_rd) cr_data_out = ph_addr ^ 16'h5A3C;
          end else w++;
        end
      end else if (!(cr_cap_addr | cr_cap_data | cr_rd | cr_wr) && cr_ack) begin
        if (!stuck_hi) begin
          if (w >= dly) begin cr_ack = 1'b0; w = 0; end
          else w++;
        end
      end else w = 0;
    end
  end

  task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                     input int d, input bit slo, input bit shi, input string tag);
    int k, exp_k, rdy_bad, wr0;
    bit exp_err;
    do @(negedge clk); while (!req_ready || cr_ack);
    dly = d; stuck_lo = slo; stuck_hi = shi;
    mon_addr = a; mon_wdata = wd; seen_cap = 0; pre_cnt = 0;
    addr_bad = 0; rd_bad = 0; wd_bad = 0; arm = 1; wr0 = wr_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    if (slo || d >= LIM) begin exp_err = 1; exp_k = LIM + 3; end
    else if (shi) begin exp_err = 1; exp_k = d + LIM + 4; end
    else begin
      exp_err = 0;
      exp_k = wr ? (2*SETUP + 6*(d+1) + 1) : (SETUP + 4*(d+1) + 1);
    end
    k = 0; rdy_bad = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (!done && req_ready) rdy_bad++;
    end while (!done && k < 3000);
    chk(k == exp_k, tag, "done latency", k, exp_k);
    chk(done_err == exp_err, exp_err ? (shi ? "R9" : "R8") : tag, "done_err", done_err, exp_err);
    chk(req_ready == 1'b1 && rdy_bad == 0, "R6", "ready low while busy", rdy_bad, 0);
    if (!exp_err) begin
      chk(pre_cnt == SETUP && addr_bad == 0, "R2", "address setup cycles", pre_cnt, SETUP);
      if (!wr) begin
        chk(done_rdata == (a ^ 16'h5A3C), "R3", "read data", done_rdata, a ^ 16'h5A3C);
        chk(rd_bad == 0 && wr_cnt == wr0, "R3", "read bus zero / no commit", rd_bad, 0);
      end else begin
        chk(wr_cnt == wr0 + 1 && wr_addr == a, "R4", "committed address", wr_addr, a);
        chk(wr_data == wd && wd_bad == 0, "R4", "committed data", wr_data, wd);
        chk(done_rdata == 16'h0, "R4", "rdata on write", done_rdata, 0);
      end
    end else begin
      chk(done_rdata == 16'h0 && wr_cnt == wr0, shi ? "R9" : "R8", "abort rdata/commit", done_rdata, 0);
    end
    arm = 0;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done pulse width", done, 0);
    stuck_lo = 0; stuck_hi = 0;
    if (exp_err) begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!req_ready || done || cr_cap_addr || cr_cap_data || cr_rd || cr_wr) bad++;
      end
      chk(bad == 0, "R11", "idle after abort", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "reset ready/done", {req_ready, done}, 2'b10);
    chk({cr_cap_addr, cr_cap_data, cr_rd, cr_wr} == 4'b0 && cr_data_in == 16'h0,
        "R1", "reset bus", cr_data_in, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && cr_data_in == 16'h0, "R1", "after reset release", req_ready, 1);

    for (int d = 0; d < 4; d++)
      for (int wr = 0; wr < 2; wr++)
        for (int j = 0; j < 3; j++) begin
          logic [15:0] a = 16'((d * 16'h1111) ^ (j * 16'h4E21) ^ (wr ? 16'h8001 : 16'h0030));
          run(wr[0], a, ~a + 16'(d), d, 0, 0, "R7");
        end
    run(1'b0, 16'hFFFF, 16'h0, LIM - 1, 0, 0, "R10");
    run(1'b1, 16'h0000, 16'hFFFF, LIM - 1, 0, 0, "R10");
    run(1'b0, 16'h1234, 16'h0, LIM, 0, 0, "R8");
    run(1'b1, 16'h2345, 16'hBEEF, 0, 1, 0, "R8");
    run(1'b0, 16'h3456, 16'h0, 1, 0, 1, "R9");
    run(1'b1, 16'h4567, 16'hCAFE, 2, 0, 0, "R7");
    chk(multi == 0, "R5", "simultaneous strobes", multi, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule